// File: doc/BRIEF.md
# Four-Channel Programmable SPI Master

This block is a register-driven SPI master that serves up to four peripherals, each on its own chip-select line. Software picks a channel, a burst length from 1 to 32 bits, and a bit rate from a two-stage divider. The divider is a 4-bit pre-divider followed by a power-of-two post-divider. Each channel has its own clock phase, clock polarity and select polarity. Words to send are queued in a transmit FIFO. Words clocked in from the peripheral collect in a receive FIFO.

Software starts a run by setting the exchange bit. The block then asserts the chosen select line and shifts out every queued word, most significant bit first. It captures one received word per sent word, releases the select line, and clears the exchange bit by itself. One interrupt output can be raised when the TX FIFO is empty, when received data is waiting, or both.

Bus registers use byte offsets on a 5-bit address:
- 0x00: RX data.
- 0x04: TX data.
- 0x08: control.
- 0x0C: channel config.
- 0x10: interrupt enable.
- 0x18: status.

Writes take effect at the clock edge. Read data is combinational from the address. A read of RX data pops the FIFO at the clock edge.

Top module: `spi_chan_master`

## Requirements
- R1: After reset, the control, status and RX data reads return 0, `irq` is 0, and all four `spi_cs` lines are 1 (inactive, since no channel is active-high).
- R2: A write to TX data (0x04) only queues the word. No select line changes and no bit clock runs until an exchange is started.
- R3: Setting control bit 2 (exchange) while control bit 0 (enable) is 1 sends every queued word, most significant bit first. Each word uses B = control[24:20] + 1 bits, taken from the low B bits of the word. Control bits 31:25 have no effect on B.
- R4: Every word sent produces one RX FIFO entry. That entry holds the B bits sampled on `spi_miso`, in the low bits, with the upper bits 0. Status bit 3 is 1 exactly while the RX FIFO holds a word.
- R5: Control bit 2 reads 1 while an exchange is pending or running. It returns to 0 by itself once the TX FIFO is empty and the last word has finished. An exchange started with an empty TX FIFO clears at once and asserts no select line.
- R6: One bit lasts P = max(2, (pre + 1) × 2^post) clock cycles, with pre = control[15:12] and post = control[11:8]. Consecutive sampling edges are P cycles apart.
- R7: For channel c, config bit c+4 is the clock idle level (CPOL) and config bit c is the phase (CPHA). `spi_mosi` changes only at bit boundaries. Sampling happens at mid-bit, on the rising edge when CPOL equals CPHA and on the falling edge otherwise.
- R8: Control[19:18] selects the channel. During an exchange, only that channel's select line sits at its active level, which is 1 if config bit c+12 is set and 0 otherwise. The line stays active from before the first clock edge until after the last. At all other times every line sits at its inactive level.
- R9: `irq` = (interrupt-enable bit 0 AND TX FIFO empty) OR (interrupt-enable bit 3 AND RX FIFO not empty).
- R10: A read of RX data while the RX FIFO is empty returns 0 and leaves the FIFO unchanged.
- R11: A TX write while the TX FIFO (64 words) is full is dropped. It sets status bit 7, which stays 1 until reset.
- R12: While control bit 0 is 0, a set exchange bit stays pending without shifting any data. Enabling the block later starts the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at 0x00) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Bit clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Per-channel chip selects |

## Verification
The hardest state to reach from the ports is a full TX FIFO followed by a dropped write. Reaching it needs 65 back-to-back writes while the shifter is guaranteed not to drain the FIFO. The stimulus gets there by filling the queue with the enable bit clear and the exchange bit already set. This also shows that a pending exchange stays idle (R12). It then enables the block and confirms that exactly 64 words come out on the wire. Random exchanges then sweep channel, mode, burst length and divider. A bench-side serial monitor rebuilds each word from the sampling edges and measures their spacing.

// File: rtl/spi_cm_pkg.sv
package spi_cm_pkg;
  localparam int CHANNELS = 4;
  localparam int DATA_W   = 32;
  localparam int PER_W    = 20;

  localparam logic [4:0] ADDR_RX   = 5'h00;
  localparam logic [4:0] ADDR_TX   = 5'h04;
  localparam logic [4:0] ADDR_CTRL = 5'h08;
  localparam logic [4:0] ADDR_CFG  = 5'h0C;
  localparam logic [4:0] ADDR_IEN  = 5'h10;
  localparam logic [4:0] ADDR_STAT = 5'h18;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_t;

  // cycles per bit: (pre+1) << post, never below two so both clock halves exist
  function automatic logic [PER_W-1:0] bit_period(input logic [3:0] pre, input logic [3:0] post);
    logic [PER_W-1:0] p;
    p = PER_W'(pre) + PER_W'(1);
    p = p << post;
    if (p < PER_W'(2)) p = PER_W'(2);
    return p;
  endfunction

  // move a word of len bits (1..32) up so that its top bit sits at bit 31
  function automatic logic [DATA_W-1:0] align_msb(input logic [DATA_W-1:0] w, input logic [5:0] len);
    return w << (6'd32 - len);
  endfunction
endpackage

// File: rtl/spi_cm_fifo.sv
module spi_cm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/spi_cm_engine.sv
module spi_cm_engine
  import spi_cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  input  logic [PER_W-1:0]  period_in,
  input  logic [5:0]        len_in,
  input  logic              cpol_in,
  input  logic              cpha_in,
  input  logic [1:0]        chan_in,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_act,
  output logic [1:0]        chan_q,
  output logic              done
);
  eng_state_t        st;
  logic [PER_W-1:0]  cnt, per_q, half_q;
  logic [5:0]        len_q;
  logic              cpol_q, cpha_q;
  logic [DATA_W-1:0] sh, rsh;
  logic [4:0]        bitn;
  logic              last_cyc, mid_cyc, word_end, first_half;

  assign last_cyc   = (cnt == per_q - PER_W'(1));
  assign mid_cyc    = (cnt == half_q - PER_W'(1));
  assign word_end   = (st == ST_SHIFT) && last_cyc && (bitn == 5'd0);
  assign first_half = (cnt < half_q);

  assign tx_pop  = ((st == ST_LEAD) && last_cyc) || (word_end && !tx_empty);
  assign rx_push = word_end;
  assign rx_word = rsh;
  assign done    = ((st == ST_IDLE) && start && tx_empty) || ((st == ST_TRAIL) && last_cyc);
  assign cs_act  = (st != ST_IDLE);
  assign mosi    = (st == ST_SHIFT) ? sh[DATA_W-1] : 1'b0;

  always_comb begin
    if (st == ST_SHIFT)     sclk = cpol_q ^ (cpha_q ? first_half : !first_half);
    else if (st == ST_IDLE) sclk = cpol_in;
    else                    sclk = cpol_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      per_q  <= PER_W'(2);
      half_q <= PER_W'(1);
      len_q  <= 6'd32;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      chan_q <= 2'd0;
      sh     <= '0;
      rsh    <= '0;
      bitn   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start && !tx_empty) begin
            per_q  <= period_in;
            half_q <= period_in >> 1;
            len_q  <= len_in;
            cpol_q <= cpol_in;
            cpha_q <= cpha_in;
            chan_q <= chan_in;
            cnt    <= '0;
            st     <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (last_cyc) begin
            cnt  <= '0;
            sh   <= align_msb(tx_word, len_q);
            rsh  <= '0;
            bitn <= 5'(len_q - 6'd1);
            st   <= ST_SHIFT;
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
        ST_SHIFT: begin
          if (mid_cyc) rsh <= {rsh[DATA_W-2:0], miso};
          if (last_cyc) begin
            cnt <= '0;
            if (bitn == 5'd0) begin
              if (!tx_empty) begin
                sh   <= align_msb(tx_word, len_q);
                rsh  <= '0;
                bitn <= 5'(len_q - 6'd1);
              end else begin
                st <= ST_TRAIL;
              end
            end else begin
              sh   <= sh << 1;
              bitn <= bitn - 5'd1;
            end
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
        default: begin
          if (last_cyc) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + PER_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_chan_master.sv
module spi_chan_master
  import spi_cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [31:0] ctrl_q, cfg_q, ien_q;
  logic        xch_q, ovf_q;
  logic        wr_ctrl, wr_cfg, wr_ien, tx_wr, rx_rd;
  logic        tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
  logic [CW-1:0] tx_count, rx_count;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic        en, start, eng_done, eng_cs;
  logic [1:0]  eng_chan, chan_live;
  logic [3:0]  pha_v, pol_v, ah_v;
  logic [5:0]  len_live;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
  assign wr_ien  = bus_wr && (bus_addr == ADDR_IEN);
  assign tx_wr   = bus_wr && (bus_addr == ADDR_TX);
  assign rx_rd   = bus_rd && (bus_addr == ADDR_RX);

  assign en        = ctrl_q[0];
  assign chan_live = ctrl_q[19:18];
  assign len_live  = {1'b0, ctrl_q[24:20]} + 6'd1;
  assign pha_v     = cfg_q[3:0];
  assign pol_v     = cfg_q[7:4];
  assign ah_v      = cfg_q[15:12];
  assign start     = xch_q && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      ien_q  <= '0;
      xch_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & ~32'h4;
      if (wr_cfg)  cfg_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata;
      if (wr_ctrl && bus_wdata[2]) xch_q <= 1'b1;
      else if (eng_done)           xch_q <= 1'b0;
      if (tx_wr && tx_full) ovf_q <= 1'b1;
    end
  end

  spi_cm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_count));

  spi_cm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_rd),
    .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_count));

  spi_cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_empty(tx_empty), .tx_word(tx_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .period_in(bit_period(ctrl_q[15:12], ctrl_q[11:8])), .len_in(len_live),
    .cpol_in(pol_v[chan_live]), .cpha_in(pha_v[chan_live]), .chan_in(chan_live),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .cs_act(eng_cs),
    .chan_q(eng_chan), .done(eng_done));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_cs
    assign spi_cs[c] = (eng_cs && (eng_chan == 2'(c))) ? ah_v[c] : ~ah_v[c];
  end

  assign irq = (ien_q[0] && tx_empty) || (ien_q[3] && !rx_empty);

  always_comb begin
    case (bus_addr)
      ADDR_RX:   bus_rdata = rx_empty ? '0 : rx_head;
      ADDR_CTRL: bus_rdata = ctrl_q | {29'b0, xch_q, 2'b0};
      ADDR_CFG:  bus_rdata = cfg_q;
      ADDR_IEN:  bus_rdata = ien_q;
      ADDR_STAT: bus_rdata = {24'b0, ovf_q, 3'b0, !rx_empty, 1'b0, rx_full, 1'b0};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_cm_checker.sv
module spi_cm_checker #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr,
  input logic          tx_full,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          tx_empty,
  input logic          rx_empty,
  input logic          rx_rd,
  input logic          rx_push,
  input logic          ovf,
  input logic          xch,
  input logic          eng_cs,
  input logic          en,
  input logic          ien0,
  input logic          ien3,
  input logic          irq,
  input logic [3:0]    spi_cs,
  input logic [3:0]    act_hi
);
  assert_drop_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !tx_pop) |=> (tx_count == $past(tx_count)));
  assert_ovf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> ovf);
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_xch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch) |-> !eng_cs);
  assert_irq_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien3 && !rx_empty) |-> irq);
  assert_irq_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien0 && tx_empty) |-> irq);
  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien0 && !ien3) |-> !irq);
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !rx_push) |=> rx_empty);
  assert_one_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(spi_cs ^ ~act_hi) <= 1);
  assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_cs |-> (spi_cs == ~act_hi));
  assert_hold_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !eng_cs) |=> !eng_cs);
endmodule

bind spi_chan_master spi_cm_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .tx_pop(tx_pop),
  .tx_count(tx_count), .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_rd(rx_rd),
  .rx_push(rx_push), .ovf(ovf_q), .xch(xch_q), .eng_cs(eng_cs), .en(en),
  .ien0(ien_q[0]), .ien3(ien_q[3]), .irq(irq), .spi_cs(spi_cs), .act_hi(ah_v));

// File: tb/spi_chan_master_test.sv
module spi_chan_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs;
  logic inv_miso = 1'b0;

  assign spi_miso = inv_miso ? ~spi_mosi : spi_mosi;

  spi_chan_master uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side view of the programmed setup
  logic [3:0]  tb_ah = 4'h0;
  logic [1:0]  tb_ch = 2'd0;
  int          tb_len = 8;
  logic        samp_lvl = 1'b1;
  logic [31:0] tb_ctrl = '0;
  logic [31:0] tb_ien = '0;
  logic [31:0] tx_q [80];
  int          tx_n = 0;

  // serial monitor
  bit          mon_en = 0, cs_seen = 0, cs_bad = 0;
  logic        prev_sclk = 1'b0;
  logic [31:0] cap_sh = '0;
  logic [31:0] cap_words [80];
  int          capn = 0, ncap = 0, edge_idx = 0, last_edge = 0, per_meas = 0;

  function automatic logic [31:0] mask_of(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic int exp_period(input int pre, input int post);
    int p;
    p = (pre + 1) * (2 ** post);
    return (p < 2) ? 2 : p;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (spi_cs != ~tb_ah) begin
        cs_seen = 1;
        if (spi_cs != (~tb_ah ^ (4'h1 << tb_ch))) cs_bad = 1;
      end
      if (spi_sclk !== prev_sclk && spi_sclk == samp_lvl) begin
        if (spi_cs == ~tb_ah) cs_bad = 1;
        cap_sh = {cap_sh[30:0], spi_mosi};
        capn++;
        if (edge_idx == 1) per_meas = cyc - last_edge;
        last_edge = cyc;
        edge_idx++;
        if (capn == tb_len) begin
          cap_words[ncap] = cap_sh & mask_of(tb_len);
          ncap++;
          capn = 0;
          cap_sh = '0;
        end
      end
    end
    prev_sclk = spi_sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg_set(input int ch, input bit pol, input bit pha, input bit ah, input int len,
                         input int pre, input int post, input bit inv, input logic [6:0] hi, input bit en);
    logic [31:0] cfg;
    cfg = (32'(pha) << ch) | (32'(pol) << (ch + 4)) | (32'(ah) << (ch + 12));
    tb_ah = 4'(32'(ah) << ch);
    tb_ch = 2'(ch);
    tb_len = len;
    samp_lvl = (pol == pha);
    inv_miso = inv;
    tb_ctrl = (32'(hi) << 25) | (32'(len - 1) << 20) | (32'(ch) << 18) |
              (32'(pre) << 12) | (32'(post) << 8) | 32'hF0;
    bus_write(5'h0C, cfg);
    bus_write(5'h08, tb_ctrl | 32'(en));
    repeat (2) @(negedge clk);
    chk(spi_sclk == pol, "R7 idle clock level", 32'(spi_sclk), 32'(pol));
    chk(spi_cs == ~tb_ah, "R8 selects inactive", 32'(spi_cs), 32'(~tb_ah));
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      tx_q[tx_n] = $urandom;
      bus_write(5'h04, tx_q[tx_n]);
      tx_n++;
    end
  endtask

  task automatic mon_clear();
    ncap = 0; capn = 0; edge_idx = 0; cs_bad = 0; cs_seen = 0; cap_sh = '0; per_meas = 0;
    mon_en = 1;
  endtask

  task automatic fire_and_check(input int nexp, input int pre, input int post);
    logic [31:0] r, e;
    int k;
    bus_write(5'h08, tb_ctrl | 32'h5);
    bus_read(5'h08, r);
    chk(r[2] == 1'b1, "R5 exchange bit set while running", r, 32'h4);
    k = 0;
    while (r[2] && k < 40000) begin bus_read(5'h08, r); k++; end
    chk(r[2] == 1'b0, "R5 exchange bit self-clears", r, 32'h0);
    mon_en = 0;
    chk(ncap == nexp, "R3 word count on wire", 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp && i < ncap; i++) begin
      e = tx_q[i] & mask_of(tb_len);
      chk(cap_words[i] == e, "R3 MSB-first word on wire", cap_words[i], e);
    end
    chk(!cs_bad, "R8 only selected line active during exchange", 32'(cs_bad), 0);
    if (nexp * tb_len >= 2)
      chk(per_meas == exp_period(pre, post), "R6 bit period", 32'(per_meas), 32'(exp_period(pre, post)));
    e = 32'(tb_ien[0] | tb_ien[3]);
    chk(irq == e[0], "R9 irq with rx data", 32'(irq), e);
    for (int i = 0; i < nexp; i++) begin
      bus_read(5'h00, r);
      e = (inv_miso ? ~tx_q[i] : tx_q[i]) & mask_of(tb_len);
      chk(r == e, "R4 received word", r, e);
    end
    bus_read(5'h18, r);
    chk(r[3] == 1'b0, "R4 rx ready clear after drain", r, 32'h0);
    chk(irq == tb_ien[0], "R9 irq after drain", 32'(irq), 32'(tb_ien[0]));
    tx_n = 0;
  endtask

  task automatic run_xfer(input int ch, input bit pol, input bit pha, input bit ah, input int len,
                          input int pre, input int post, input int n, input bit inv, input logic [6:0] hi);
    cfg_set(ch, pol, pha, ah, len, pre, post, inv, hi, 1'b1);
    mon_clear();
    push_words(n);
    chk(!cs_seen, "R2 tx write only queues", 32'(spi_cs), 32'(~tb_ah));
    fire_and_check(n, pre, post);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int s;
    s = $urandom(32'h5EED_1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    bus_read(5'h18, r); chk(r == 0, "R1 status after reset", r, 0);
    bus_read(5'h08, r); chk(r == 0, "R1 control after reset", r, 0);
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    chk(spi_cs == 4'hF, "R1 selects after reset", 32'(spi_cs), 32'hF);
    bus_read(5'h00, r); chk(r == 0, "R10 empty rx read returns 0", r, 0);
    bus_read(5'h18, r); chk(r[3] == 0, "R10 empty read leaves fifo empty", r, 0);
    // interrupt sources
    tb_ien = 32'h1; bus_write(5'h10, tb_ien);
    chk(irq == 1'b1, "R9 tx-empty irq", 32'(irq), 1);
    tb_ien = 32'h8; bus_write(5'h10, tb_ien);
    chk(irq == 1'b0, "R9 rx-ready irq idle", 32'(irq), 0);
    // exchange with nothing queued
    cfg_set(1, 0, 0, 0, 8, 0, 0, 0, 7'h0, 1'b1);
    mon_clear();
    bus_write(5'h08, tb_ctrl | 32'h5);
    bus_read(5'h08, r);
    chk(r[2] == 1'b0, "R5 empty exchange clears at once", r, 0);
    mon_en = 0;
    chk(!cs_seen, "R5 empty exchange leaves selects idle", 32'(cs_seen), 0);
    // directed corners: every mode, shortest and longest bursts, clamped and wide divider
    for (int m = 0; m < 4; m++)
      run_xfer(m, m[1], m[0], m[0] ^ m[1], 8, 0, 1, 2, m[0], 7'h0);
    run_xfer(2, 0, 0, 1, 1, 0, 0, 3, 1, 7'h55);
    run_xfer(3, 1, 1, 0, 32, 0, 0, 2, 0, 7'h7F);
    run_xfer(0, 0, 1, 1, 5, 1, 2, 2, 1, 7'h2A);
    // random sweep
    tb_ien = 32'h9; bus_write(5'h10, tb_ien);
    for (int t = 0; t < 10; t++)
      run_xfer($urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom), 1 + $urandom % 32,
               $urandom % 3, $urandom % 2, 1 + $urandom % 6, 1'($urandom), 7'($urandom));
    // overflow and disabled pending exchange
    cfg_set(2, 0, 0, 0, 8, 0, 0, 0, 7'h0, 1'b0);
    mon_clear();
    push_words(65);
    bus_read(5'h18, r);
    chk(r[7] == 1'b1, "R11 overflow flag on full write", r, 32'h80);
    bus_write(5'h08, tb_ctrl | 32'h4);
    repeat (40) @(negedge clk);
    bus_read(5'h08, r);
    chk(r[2] == 1'b1, "R12 exchange pending while disabled", r, 32'h4);
    chk(!cs_seen && ncap == 0, "R12 no shifting while disabled", 32'(ncap), 0);
    fire_and_check(64, 0, 0);
    bus_read(5'h18, r);
    chk(r[7] == 1'b1, "R11 overflow flag sticky", r, 32'h80);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule